// File: doc/BRIEF.md
# Input Admission Stage with Slot Delay Buffer

This block sits in front of one input port of a deflection-routed multistage switch fabric. A single packet may arrive in each slot, where one slot is one clock cycle and one packet time. The stage decides whether that packet, or one it has kept from an earlier slot, enters the fabric in the current slot. The fabric raises a busy flag when the port cannot take a packet in this slot. Without this stage, a packet that arrives on a busy port would be lost. Here it is kept in a short FIFO of `DLY_SLOTS` entries and offered to the fabric in a later slot.

Each slot, the buffered packets have precedence over a plain new arrival. When the port is free and the buffer holds a packet, the oldest buffered packet is injected and the new arrival takes the buffer position that was just freed. An arrival that carries the priority flag goes around the buffer and is injected at once. A packet is dropped only when the port is busy and the buffer is full. When `DLY_SLOTS` is 0 the buffer is absent, so every arrival on a busy port is dropped. The stage gives per-slot pulses for attempt, accept and drop, so the injection ratio can be formed outside the block as accepts over attempts.

Top module: `adm_stage`

## Requirements
- R1: After reset the buffer is empty and, with no arrival, no packet is injected (inj_valid_o=0) and none of attempt_o, accept_o or drop_o is asserted.
- R2: With the port free, the buffer empty and a valid arrival, that arrival is injected in the same slot with its payload, and inj_src_o=0 (0 means the packet came from the arrival, 1 means it came from the buffer).
- R3: While port_busy_i is high, inj_valid_o stays low.
- R4: An arrival on a busy port while the buffer has a free entry is stored: accept_o=1 and drop_o=0.
- R5: With the port free, a non-empty buffer and no priority arrival, the oldest buffered packet is injected with inj_src_o=1. A non-priority arrival in the same slot is written to the buffer, so the occupancy does not change.
- R6: A priority arrival (arr_prio_i=1) on a free port is injected in the same slot with inj_src_o=0, even when the buffer holds packets. The buffer contents are left as they were.
- R7: An arrival on a busy port while the buffer holds `DLY_SLOTS` packets is dropped (drop_o=1, accept_o=0), and the buffer contents are left as they were.
- R8: attempt_o equals arr_valid_i. Every attempt gives exactly one of accept_o or drop_o, and neither is asserted without an attempt.
- R9: With `DLY_SLOTS`=0, an arrival on a busy port is dropped, and an arrival on a free port is injected directly.
- R10: Buffered packets leave the stage in the order they arrived. Only a priority bypass can change the order of packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arr_valid_i | input | 1 | A packet arrives in this slot |
| arr_prio_i | input | 1 | The arriving packet has high priority |
| arr_data_i | input | DATA_W | Payload of the arriving packet |
| port_busy_i | input | 1 | The fabric input cannot take a packet this slot |
| inj_valid_o | output | 1 | A packet is injected this slot |
| inj_src_o | output | 1 | Source of the injected packet: 0 arrival, 1 buffer |
| inj_data_o | output | DATA_W | Payload of the injected packet |
| attempt_o | output | 1 | Pulse: an arrival tried to enter |
| accept_o | output | 1 | Pulse: the arrival was injected or stored |
| drop_o | output | 1 | Pulse: the arrival was lost |

## Verification
The directed patterns are chosen to separate the decisions from one another:
- A free port with an empty buffer shows whether an arrival goes straight through.
- Busy slots that fill the buffer and then overfill it separate storing from dropping at exactly `DLY_SLOTS` entries.
- Draining the buffer while new packets keep arriving shows whether the buffer is served first and whether the freed entry is reused in order.
- A priority arrival on top of a full buffer tells a bypass apart from a buffer-first decision.

A zero-depth instance shows that the variant without a buffer drops on every busy slot. A long random run with busy, arrival and priority patterns is compared slot by slot with a queue model, which exposes any reordering or any drop count that differs from the model.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ARR  = 2'd1,
    SEL_BUF  = 2'd2
  } inj_sel_e;

  typedef struct packed {
    inj_sel_e sel;
    logic     push;
    logic     pop;
    logic     accept;
    logic     drop;
  } adm_dec_t;
endpackage

// File: rtl/adm_fifo.sv
module adm_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  // data array carries no reset
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i); // R7
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R5
  AST_FIFO_SWAP_KEEPS_HEAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full_o) |=> full_o); // R5
endmodule

// File: rtl/adm_arbiter.sv
module adm_arbiter
  import adm_pkg::*;
(
  input  logic     arr_valid_i,
  input  logic     arr_prio_i,
  input  logic     port_busy_i,
  input  logic     buf_empty_i,
  input  logic     buf_full_i,
  output adm_dec_t dec_o
);
  always_comb begin
    dec_o = '{sel: SEL_NONE, push: 1'b0, pop: 1'b0, accept: 1'b0, drop: 1'b0};
    if (port_busy_i) begin
      if (arr_valid_i) begin
        if (!buf_full_i) begin
          dec_o.push   = 1'b1;
          dec_o.accept = 1'b1;
        end else begin
          dec_o.drop = 1'b1;
        end
      end
    end else begin
      dec_o.accept = arr_valid_i;
      if (arr_valid_i && arr_prio_i) begin
        dec_o.sel = SEL_ARR;
      end else if (!buf_empty_i) begin
        // buffer served first; arrival takes the freed entry
        dec_o.sel  = SEL_BUF;
        dec_o.pop  = 1'b1;
        dec_o.push = arr_valid_i;
      end else if (arr_valid_i) begin
        dec_o.sel = SEL_ARR;
      end
    end
  end
endmodule

// File: rtl/adm_stage.sv
module adm_stage
  import adm_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DLY_SLOTS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arr_valid_i,
  input  logic              arr_prio_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              port_busy_i,
  output logic              inj_valid_o,
  output logic              inj_src_o,
  output logic [DATA_W-1:0] inj_data_o,
  output logic              attempt_o,
  output logic              accept_o,
  output logic              drop_o
);
  localparam bit HAS_BUF = (DLY_SLOTS > 0);

  adm_dec_t          dec;
  logic              buf_empty, buf_full;
  logic [DATA_W-1:0] buf_head;

  adm_arbiter u_arb (
    .arr_valid_i (arr_valid_i),
    .arr_prio_i  (arr_prio_i),
    .port_busy_i (port_busy_i),
    .buf_empty_i (buf_empty),
    .buf_full_i  (buf_full),
    .dec_o       (dec)
  );

  generate
    if (HAS_BUF) begin : g_buf
      adm_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DLY_SLOTS)
      ) u_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (dec.push),
        .push_data_i (arr_data_i),
        .pop_i       (dec.pop),
        .head_o      (buf_head),
        .empty_o     (buf_empty),
        .full_o      (buf_full)
      );
    end else begin : g_nobuf
      assign buf_head  = '0;
      assign buf_empty = 1'b1;
      assign buf_full  = 1'b1;
    end
  endgenerate

  always_comb begin
    inj_valid_o = (dec.sel != SEL_NONE);
    inj_src_o   = (dec.sel == SEL_BUF);
    unique case (dec.sel)
      SEL_ARR: inj_data_o = arr_data_i;
      SEL_BUF: inj_data_o = buf_head;
      default: inj_data_o = '0;
    endcase
  end

  assign attempt_o = arr_valid_i;
  assign accept_o  = dec.accept;
  assign drop_o    = dec.drop;

  AST_BUSY_NO_INJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_busy_i |-> !inj_valid_o); // R3
  AST_DROP_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (port_busy_i && buf_full)); // R7
  AST_PRIO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_busy_i && arr_valid_i && arr_prio_i) |-> (inj_valid_o && !inj_src_o)); // R6
  AST_BUF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_busy_i && !buf_empty && !(arr_valid_i && arr_prio_i)) |-> (inj_valid_o && inj_src_o)); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempt_o |-> $onehot({accept_o, drop_o})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arr_valid_i |-> !(accept_o || drop_o)); // R8
  AST_FREE_EMPTY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_busy_i && buf_empty && arr_valid_i) |-> (inj_valid_o && inj_data_o == arr_data_i)); // R2
endmodule

// File: tb/adm_stage_bench.sv
module adm_stage_bench;
  localparam int DW  = 16;
  localparam int DEP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_valid, a_prio, busy;
  logic [DW-1:0] a_data;
  logic          inj_valid, inj_src, attempt, accept, drop;
  logic [DW-1:0] inj_data;
  logic          z_valid, z_src, z_att, z_acc, z_drop;
  logic [DW-1:0] z_data;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] q[$];

  always #2 clk = ~clk;

  adm_stage #(.DATA_W(DW), .DLY_SLOTS(DEP)) u_adm_stage (
    .clk_i(clk), .rst_ni(rst_n), .arr_valid_i(a_valid), .arr_prio_i(a_prio),
    .arr_data_i(a_data), .port_busy_i(busy), .inj_valid_o(inj_valid),
    .inj_src_o(inj_src), .inj_data_o(inj_data), .attempt_o(attempt),
    .accept_o(accept), .drop_o(drop));

  adm_stage #(.DATA_W(DW), .DLY_SLOTS(0)) u_adm_stage_d0 (
    .clk_i(clk), .rst_ni(rst_n), .arr_valid_i(a_valid), .arr_prio_i(a_prio),
    .arr_data_i(a_data), .port_busy_i(busy), .inj_valid_o(z_valid),
    .inj_src_o(z_src), .inj_data_o(z_data), .attempt_o(z_att),
    .accept_o(z_acc), .drop_o(z_drop));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one slot on the main instance, checked against a queue model
  task automatic step(input string tag, input logic v, input logic p,
                      input logic [DW-1:0] d, input logic b);
    logic ev, es, acc, drp, push, pop;
    logic [DW-1:0] ed;
    @(negedge clk);
    a_valid = v; a_prio = p; a_data = d; busy = b;
    #1;
    ev = 0; es = 0; ed = '0; acc = 0; drp = 0; push = 0; pop = 0;
    if (v) begin
      if (!b) acc = 1;
      else if (q.size() < DEP) begin acc = 1; push = 1; end
      else drp = 1;
    end
    if (!b) begin
      if (v && p) begin ev = 1; ed = d; end
      else if (q.size() > 0) begin ev = 1; es = 1; ed = q[0]; pop = 1; push = v; end
      else if (v) begin ev = 1; ed = d; end
    end
    chk({tag, " inj_valid"}, 32'(inj_valid), 32'(ev));
    if (ev) begin
      chk({tag, " inj_data"}, 32'(inj_data), 32'(ed));
      chk({tag, " inj_src"}, 32'(inj_src), 32'(es));
    end
    chk({tag, " R8 attempt"}, 32'(attempt), 32'(v));
    chk({tag, " accept"}, 32'(accept), 32'(acc));
    chk({tag, " drop"}, 32'(drop), 32'(drp));
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; a_valid = 0; a_prio = 0; a_data = '0; busy = 0;
    q.delete();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 inj_valid in reset", 32'(inj_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    step("R1 idle after reset", 0, 0, 16'h0, 0);
    step("R1 idle busy", 0, 0, 16'h0, 1);
  endtask

  task automatic t_pass;
    step("R2 direct", 1, 0, 16'h1111, 0);
    step("R2 direct again", 1, 0, 16'h2222, 0);
    chk("R2 src arrival", 32'(inj_src), 0);
  endtask

  task automatic t_fill_drop;
    step("R3 R4 store first", 1, 0, 16'hA001, 1);
    chk("R3 busy no inject", 32'(inj_valid), 0);
    step("R4 store second", 1, 0, 16'hA002, 1);
    step("R7 full drop", 1, 0, 16'hA003, 1);
    chk("R7 drop pulse", 32'(drop), 1);
    step("R7 full drop prio", 1, 1, 16'hA004, 1);
  endtask

  task automatic t_drain;
    step("R5 R10 head first", 1, 0, 16'hB001, 0);
    chk("R5 oldest out", 32'(inj_data), 32'hA001);
    step("R6 prio bypass", 1, 1, 16'hC001, 0);
    chk("R6 prio data", 32'(inj_data), 32'hC001);
    step("R10 second", 0, 0, 16'h0, 0);
    chk("R10 order", 32'(inj_data), 32'hA002);
    step("R10 third", 0, 0, 16'h0, 0);
    chk("R10 refill order", 32'(inj_data), 32'hB001);
    step("R2 empty again", 0, 0, 16'h0, 0);
  endtask

  task automatic t_zero_depth;
    step("R9 busy", 1, 0, 16'hD001, 1);
    chk("R9 d0 drop", 32'(z_drop), 1);
    chk("R9 d0 no accept", 32'(z_acc), 0);
    step("R9 free", 1, 0, 16'hD002, 0);
    chk("R9 d0 inject", 32'(z_valid), 1);
    chk("R9 d0 data", 32'(z_data), 32'hD002);
    chk("R9 d0 src", 32'(z_src), 0);
    chk("R9 d0 attempt", 32'(z_att), 1);
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      step("R10 R7 random", 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0),
           DW'($urandom), 1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_fill_drop();
    t_drain();
    t_zero_depth();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule